// File: doc/BRIEF.md
# HDLC Transmit Double-Pool Buffer Controller

This block buffers outgoing data for one HDLC channel between a host and a serial transmitter. It holds two byte pools that alternate. The host fills whichever pool is free, writing up to `POOL_BYTES` bytes. It then issues a transmit command. The command carries the data kind (transparent, prepared or direct) and an end-of-message flag. On an accepted command, the byte count written so far is frozen into the pool. The pool then joins the send queue, and the host side moves on to the other pool.

The transmitter side works as a valid/ready byte stream. Committed pools are drained in commit order, back to back. When a pool was committed with end-of-message, its final byte carries a frame-end strobe. Each time a pool is fully drained, a pool-ready interrupt flag is raised. A host read of the interrupt status clears it. A write-enable status output lets the host poll instead of waiting for the interrupt. A command that arrives when no pool is free, or that is malformed, is dropped and sets a sticky error flag.

Flag generation, CRC and bit stuffing belong to the downstream transmitter.

Top module: `hdlc_txpool_ctrl`

## Requirements
- R1: After reset `wr_ok` is 1, and `pool_irq`, `cmd_err` and `tx_valid` are 0.
- R2: The bytes written into a pool are offered on `tx_data` in the order they were written, once the pool is committed. Each byte carries `tx_kind` equal to the command's kind: 01 transparent, 10 prepared, 11 direct.
- R3: A pool holds at most `POOL_BYTES` bytes, and further writes to it are ignored. `wr_ok` is 0 whenever the current fill pool is full or still committed.
- R4: Pools are sent strictly in commit order. The first byte of the next committed pool is offered in the cycle right after the previous pool's last byte is accepted, with no idle cycle between them.
- R5: `tx_last` is 1 only on the final byte of a pool committed with `cmd_eom`=1. A pool committed without end-of-message never shows `tx_last`; this is legal for every kind, including prepared data that continues in the next pool.
- R6: A command issued while both pools are committed is ignored: the stream and the queued data are unaffected. It sets `cmd_err`, which then stays 1 until reset.
- R7: A command is ignored, and `cmd_err` is set, when it has kind 00 or when no byte has been written into the fill pool. The bytes already written stay in the pool for a later valid command.
- R8: `pool_irq` is set in the cycle after a pool's last byte is accepted. It stays set until `irq_rd` is sampled high, and it reads 0 in the following cycle. If a release and `irq_rd` fall in the same cycle, the set wins.
- R9: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R10: A write sampled in the same cycle as `cmd_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | DATA_W | Host byte |
| cmd_valid | input | 1 | Transmit command strobe |
| cmd_kind | input | 2 | Data kind: 01 transparent, 10 prepared, 11 direct, 00 invalid |
| cmd_eom | input | 1 | End-of-message with this command |
| irq_rd | input | 1 | Host read of interrupt status; clears `pool_irq` |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| wr_ok | output | 1 | Fill pool is free and not full |
| pool_irq | output | 1 | Pool-ready interrupt flag |
| cmd_err | output | 1 | Sticky flag for a dropped command |
| tx_valid | output | 1 | A byte is offered |
| tx_data | output | DATA_W | Offered byte |
| tx_kind | output | 2 | Kind of the pool being sent |
| tx_last | output | 1 | Frame-end strobe on the final byte of an end-of-message pool |

## Verification
The bench uses the default `POOL_BYTES`=32 and `DATA_W`=8. With these values it can attempt 40 writes into one pool, observe the clamp at exactly 32 bytes, and follow a full 32-byte pool with a short one to check the zero-gap hand-over across a full-length boundary. The 5-bit index wrap and the 6-bit count are both reached in a single pool. A scoreboard takes expected bytes from each command while `tx_ready` is held high, held low, or toggled in a pattern.

// File: rtl/hdlc_txpool_pkg.sv
package hdlc_txpool_pkg;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'b00,
        KIND_TRANSP = 2'b01,
        KIND_PREP   = 2'b10,
        KIND_DIRECT = 2'b11
    } tx_kind_e;

    localparam int unsigned NUM_POOLS = 2;

    // A command is usable when its kind is defined and the pool is not empty.
    function automatic logic cmd_usable(input tx_kind_e kind, input logic nonempty);
        return (kind != KIND_NONE) && nonempty;
    endfunction

endpackage

// File: rtl/txpool_store.sv
module txpool_store #(
    parameter int unsigned POOL_BYTES = 32,
    parameter int unsigned DATA_W     = 8,
    localparam int unsigned IDX_W     = $clog2(POOL_BYTES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wsel,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rsel,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    import hdlc_txpool_pkg::*;

    logic [DATA_W-1:0] mem [NUM_POOLS][POOL_BYTES];

    for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
        always_ff @(posedge clk) begin
            if (we && (wsel == 1'(p))) begin
                mem[p][waddr] <= wdata;
            end
        end
    end

    assign rdata = mem[rsel][raddr];

endmodule

// File: rtl/txpool_fill.sv
module txpool_fill #(
    parameter int unsigned POOL_BYTES = 32,
    parameter int unsigned DATA_W     = 8,
    localparam int unsigned IDX_W     = $clog2(POOL_BYTES),
    localparam int unsigned CNT_W     = $clog2(POOL_BYTES + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      cmd_valid,
    input  logic [1:0]                cmd_kind,
    input  logic                      cmd_eom,
    input  logic [1:0]                busy,
    output logic                      we,
    output logic                      wsel,
    output logic [IDX_W-1:0]          waddr,
    output logic [DATA_W-1:0]         wdata,
    output logic                      commit,
    output logic                      commit_sel,
    output logic [CNT_W-1:0]          commit_cnt,
    output hdlc_txpool_pkg::tx_kind_e commit_kind,
    output logic                      commit_eom,
    output logic                      wr_ok,
    output logic                      cmd_bad
);
    import hdlc_txpool_pkg::*;

    logic             fill_sel;
    logic [CNT_W-1:0] wcount;
    logic             pool_free;

    assign pool_free   = !busy[fill_sel];
    assign wr_ok       = pool_free && (wcount < CNT_W'(POOL_BYTES));
    assign we          = wr_en && !cmd_valid && wr_ok;
    assign wsel        = fill_sel;
    assign waddr       = wcount[IDX_W-1:0];
    assign wdata       = wr_data;

    assign commit_kind = tx_kind_e'(cmd_kind);
    assign commit_eom  = cmd_eom;
    assign commit_cnt  = wcount;
    assign commit_sel  = fill_sel;
    assign commit      = cmd_valid && pool_free && cmd_usable(commit_kind, wcount != '0);
    assign cmd_bad     = cmd_valid && !commit;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_sel <= 1'b0;
            wcount   <= '0;
        end else if (commit) begin
            fill_sel <= ~fill_sel;
            wcount   <= '0;
        end else if (we) begin
            wcount   <= wcount + 1'b1;
        end
    end

endmodule

// File: rtl/txpool_drain.sv
module txpool_drain #(
    parameter int unsigned POOL_BYTES = 32,
    parameter int unsigned DATA_W     = 8,
    localparam int unsigned IDX_W     = $clog2(POOL_BYTES),
    localparam int unsigned CNT_W     = $clog2(POOL_BYTES + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      commit,
    input  logic                      commit_sel,
    input  logic [CNT_W-1:0]          commit_cnt,
    input  hdlc_txpool_pkg::tx_kind_e commit_kind,
    input  logic                      commit_eom,
    input  logic                      tx_ready,
    input  logic [DATA_W-1:0]         rdata,
    output logic [1:0]                busy,
    output logic                      rsel,
    output logic [IDX_W-1:0]          raddr,
    output logic                      tx_valid,
    output logic [DATA_W-1:0]         tx_data,
    output hdlc_txpool_pkg::tx_kind_e tx_kind,
    output logic                      tx_last,
    output logic                      release_pool
);
    import hdlc_txpool_pkg::*;

    logic [CNT_W-1:0] cnt_q  [NUM_POOLS];
    tx_kind_e         kind_q [NUM_POOLS];
    logic [1:0]       eom_q;
    logic             send_sel;
    logic [IDX_W-1:0] rd_idx;
    logic             at_end;

    assign rsel         = send_sel;
    assign raddr        = rd_idx;
    assign tx_valid     = busy[send_sel];
    assign tx_data      = rdata;
    assign tx_kind      = kind_q[send_sel];
    assign at_end       = (CNT_W'(rd_idx) + 1'b1) == cnt_q[send_sel];
    assign tx_last      = tx_valid && at_end && eom_q[send_sel];
    assign release_pool = tx_valid && tx_ready && at_end;

    for (genvar p = 0; p < NUM_POOLS; p++) begin : g_desc
        always_ff @(posedge clk) begin
            if (rst) begin
                busy[p]   <= 1'b0;
                cnt_q[p]  <= '0;
                kind_q[p] <= KIND_NONE;
                eom_q[p]  <= 1'b0;
            end else if (commit && (commit_sel == 1'(p))) begin
                busy[p]   <= 1'b1;
                cnt_q[p]  <= commit_cnt;
                kind_q[p] <= commit_kind;
                eom_q[p]  <= commit_eom;
            end else if (release_pool && (send_sel == 1'(p))) begin
                busy[p]   <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            send_sel <= 1'b0;
            rd_idx   <= '0;
        end else if (release_pool) begin
            send_sel <= ~send_sel;
            rd_idx   <= '0;
        end else if (tx_valid && tx_ready) begin
            rd_idx   <= rd_idx + 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_txpool_ctrl.sv
module hdlc_txpool_ctrl #(
    parameter int unsigned POOL_BYTES = 32,
    parameter int unsigned DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_kind,
    input  logic              cmd_eom,
    input  logic              irq_rd,
    input  logic              tx_ready,
    output logic              wr_ok,
    output logic              pool_irq,
    output logic              cmd_err,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic [1:0]        tx_kind,
    output logic              tx_last
);
    import hdlc_txpool_pkg::*;

    localparam int unsigned IDX_W = $clog2(POOL_BYTES);
    localparam int unsigned CNT_W = $clog2(POOL_BYTES + 1);

    logic              we, wsel, rsel;
    logic [IDX_W-1:0]  waddr, raddr;
    logic [DATA_W-1:0] wdata, rdata;
    logic              commit, commit_sel, commit_eom, cmd_bad, release_pool;
    logic [CNT_W-1:0]  commit_cnt;
    tx_kind_e          commit_kind, kind_out;
    logic [1:0]        busy;

    txpool_fill #(.POOL_BYTES(POOL_BYTES), .DATA_W(DATA_W)) u_fill (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_data(wr_data),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_eom(cmd_eom),
        .busy(busy),
        .we(we), .wsel(wsel), .waddr(waddr), .wdata(wdata),
        .commit(commit), .commit_sel(commit_sel), .commit_cnt(commit_cnt),
        .commit_kind(commit_kind), .commit_eom(commit_eom),
        .wr_ok(wr_ok), .cmd_bad(cmd_bad)
    );

    txpool_store #(.POOL_BYTES(POOL_BYTES), .DATA_W(DATA_W)) u_store (
        .clk(clk),
        .we(we), .wsel(wsel), .waddr(waddr), .wdata(wdata),
        .rsel(rsel), .raddr(raddr), .rdata(rdata)
    );

    txpool_drain #(.POOL_BYTES(POOL_BYTES), .DATA_W(DATA_W)) u_drain (
        .clk(clk), .rst(rst),
        .commit(commit), .commit_sel(commit_sel), .commit_cnt(commit_cnt),
        .commit_kind(commit_kind), .commit_eom(commit_eom),
        .tx_ready(tx_ready), .rdata(rdata),
        .busy(busy), .rsel(rsel), .raddr(raddr),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_kind(kind_out),
        .tx_last(tx_last), .release_pool(release_pool)
    );

    assign tx_kind = kind_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            pool_irq <= 1'b0;
            cmd_err  <= 1'b0;
        end else begin
            if (release_pool) begin
                pool_irq <= 1'b1;
            end else if (irq_rd) begin
                pool_irq <= 1'b0;
            end
            if (cmd_bad) begin
                cmd_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/hdlc_txpool_checker.sv
module hdlc_txpool_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_last,
    input logic              pool_irq,
    input logic              irq_rd,
    input logic              cmd_err
);

    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        cmd_err |=> cmd_err); // R6

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid); // R5

    AST_IRQ_FROM_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        $rose(pool_irq) |-> $past(tx_valid && tx_ready)); // R8

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pool_irq && !irq_rd) |=> pool_irq); // R8

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (pool_irq && irq_rd && !(tx_valid && tx_ready)) |=> !pool_irq); // R8

endmodule

bind hdlc_txpool_ctrl hdlc_txpool_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .pool_irq(pool_irq), .irq_rd(irq_rd), .cmd_err(cmd_err)
);

// File: tb/hdlc_txpool_ctrl_bench.sv
module hdlc_txpool_ctrl_bench;

    localparam int unsigned POOL_BYTES = 32;
    localparam int unsigned DATA_W     = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_kind = 2'b00;
    logic              cmd_eom = 1'b0;
    logic              irq_rd = 1'b0;
    logic              tx_ready = 1'b0;
    logic              wr_ok, pool_irq, cmd_err, tx_valid, tx_last;
    logic [DATA_W-1:0] tx_data;
    logic [1:0]        tx_kind;

    int checks = 0;
    int fails  = 0;
    int ready_mode = 1;   // 0 low, 1 high, 2 pattern
    logic [7:0] lfsr = 8'hA5;

    // expected item: {kind, last, data}
    logic [DATA_W+2:0] exp_q [$];

    always #5 clk = ~clk;

    hdlc_txpool_ctrl #(.POOL_BYTES(POOL_BYTES), .DATA_W(DATA_W)) u_hdlc_txpool_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_eom(cmd_eom),
        .irq_rd(irq_rd), .tx_ready(tx_ready),
        .wr_ok(wr_ok), .pool_irq(pool_irq), .cmd_err(cmd_err),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_kind(tx_kind), .tx_last(tx_last)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // ready driver
    always @(posedge clk) begin
        #1;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (ready_mode)
            0:       tx_ready <= 1'b0;
            1:       tx_ready <= 1'b1;
            default: tx_ready <= lfsr[0];
        endcase
    end

    // monitor: R2 order/kind, R5 last marking
    always @(negedge clk) begin
        if (!rst && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected byte", {21'd0, tx_kind, tx_last, tx_data}, 32'hFFFF_FFFF);
            end else begin
                logic [DATA_W+2:0] e;
                e = exp_q.pop_front();
                check("R2/R5 stream item", {21'd0, tx_kind, tx_last, tx_data}, {21'd0, e});
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; step(); step(); rst = 1'b0; #2;
        exp_q.delete();
    endtask

    task automatic wait_free();
        while (!wr_ok) step();
    endtask

    task automatic put_bytes(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            wr_en = 1'b1; wr_data = DATA_W'(base + i); step();
        end
        wr_en = 1'b0;
    endtask

    task automatic commit(input logic [1:0] kind, input logic eom, input int nexp, input int base);
        for (int i = 0; i < nexp; i++) begin
            exp_q.push_back({kind, (eom && i == nexp - 1), DATA_W'(base + i)});
        end
        cmd_valid = 1'b1; cmd_kind = kind; cmd_eom = eom; step();
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) step();
        step(); step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected done");
        summary();
    end

    initial begin
        logic [DATA_W-1:0] held;
        int run;
        do_reset();
        @(negedge clk);
        check("R1 wr_ok", wr_ok, 1);
        check("R1 pool_irq", pool_irq, 0);
        check("R1 cmd_err", cmd_err, 0);
        check("R1 tx_valid", tx_valid, 0);
        step();

        // R7: empty-pool command
        ready_mode = 1;
        commit(2'b10, 1'b1, 0, 0);
        @(negedge clk);
        check("R7 cmd_err after empty command", cmd_err, 1);
        check("R7 no send after empty command", tx_valid, 0);
        step();
        // R7: kind 00 keeps bytes; R10: write during command ignored
        put_bytes(2, 8'h40);
        wr_en = 1'b1; wr_data = 8'hEE;
        commit(2'b00, 1'b1, 0, 0);
        wr_en = 1'b0;
        @(negedge clk);
        check("R7 no send after kind 00", tx_valid, 0);
        step();
        commit(2'b01, 1'b1, 2, 8'h40);   // R10: 8'hEE must not appear
        drain();
        @(negedge clk);
        check("R8 pool_irq after release", pool_irq, 1);
        step();
        irq_rd = 1'b1; step(); irq_rd = 1'b0;
        @(negedge clk);
        check("R8 pool_irq cleared by read", pool_irq, 0);
        step();

        // fresh start clears sticky error
        do_reset();
        @(negedge clk);
        check("R1 cmd_err after second reset", cmd_err, 0);
        step();

        // R2/R5 under toggling ready
        ready_mode = 2;
        wait_free(); put_bytes(5, 8'h10); commit(2'b01, 1'b1, 5, 8'h10);
        wait_free(); put_bytes(3, 8'h20); commit(2'b10, 1'b0, 3, 8'h20);
        wait_free(); put_bytes(4, 8'h30); commit(2'b10, 1'b1, 4, 8'h30);
        wait_free(); put_bytes(7, 8'h50); commit(2'b11, 1'b0, 7, 8'h50);
        drain();
        check("R2 all bytes consumed", exp_q.size(), 0);

        // R3: clamp at POOL_BYTES
        ready_mode = 0;
        step(); step();
        wait_free();
        put_bytes(POOL_BYTES, 8'h80);
        @(negedge clk);
        check("R3 wr_ok low on full pool", wr_ok, 0);
        step();
        put_bytes(8, 8'hC0);             // ignored
        commit(2'b11, 1'b1, POOL_BYTES, 8'h80);
        @(negedge clk);
        check("R3 wr_ok high for other pool", wr_ok, 1);
        step();
        put_bytes(6, 8'h08);
        commit(2'b01, 1'b1, 6, 8'h08);
        @(negedge clk);
        check("R3 wr_ok low with both pools committed", wr_ok, 0);
        held = tx_data;
        step();
        // R6: third command dropped
        commit(2'b01, 1'b1, 0, 0);
        @(negedge clk);
        check("R6 cmd_err after overflow command", cmd_err, 1);
        check("R6 stream unaffected", {tx_valid, tx_data}, {1'b1, 8'h80});
        check("R9 data held while not ready", tx_data, held);
        step();
        // R4: no gap between pools
        ready_mode = 1;
        run = 0;
        for (int i = 0; i < POOL_BYTES + 6; i++) begin
            @(negedge clk);
            if (tx_valid) run++;
        end
        check("R4 back-to-back pools", run, POOL_BYTES + 6);
        drain();
        @(negedge clk);
        check("R6 cmd_err still set", cmd_err, 1);
        check("R2 final queue empty", exp_q.size(), 0);
        summary();
    end

endmodule